// File: doc/BRIEF.md
# Multi-Port Hardware Lock Bank

This block holds a bank of single-bit mutual-exclusion flags that several processors share in order to agree on who may touch a shared resource. Every processor has its own simple register-bus port. A lock is taken by reading its word. The read is an atomic test-and-set, so a processor that reads back 0 already owns the lock. Writing 0 to the word hands the lock back.

The number of locks is set at build time to 32, 64, 128 or 256. A read-only status word reports that count, so software can size its lock table. When two or more ports contend in one cycle, the order is fixed: releases are applied before acquires, and among the acquires the port with the lowest index wins.

Top module: `lock_bank_top`

## Requirements
- R1: After reset every lock is free, so the first read of any lock returns 0.
- R2: A read of a free lock returns 0 and marks that lock taken in the same operation.
- R3: A read of a taken lock returns 1 and leaves the lock taken.
- R4: A write of value 0 to a lock word frees the lock, so the next read of it returns 0.
- R5: A write of any nonzero value to a lock word changes nothing.
- R6: Lock i sits at byte address 0x800 + 4*i. Address bits [1:0] are ignored, and each lock is independent of the others.
- R7: A read of byte address 0x14 returns the lock count divided by 32 in bits [27:24], coded one-hot (1, 2, 4 or 8), with every other bit 0. Writes to that address are ignored.
- R8: When several ports read the same free lock in one cycle, only the lowest-indexed of them gets 0. The others get 1.
- R9: When a release and an acquire of the same lock fall in one cycle, the release is applied first, so the acquiring port gets 0 and holds the lock.
- R10: A read of a lock index at or beyond the configured count (an address in 0x800 to 0xFFF) returns 1 and changes no state. A write of 0 there frees nothing.
- R11: A response is given exactly one cycle after each request. rsp_valid is high in the cycle after req_valid and low otherwise, and read data is valid with it. The response to a write carries data 0.
- R12: A read of any other address returns 0, and a write to it changes no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_PORTS | Per-port request strobe |
| req_write | input | N_PORTS | Per-port request type: 1 is a write, 0 is a read |
| req_addr | input | N_PORTS x ADDR_W | Per-port byte address |
| req_wdata | input | N_PORTS x DATA_W | Per-port write data |
| rsp_valid | output | N_PORTS | Per-port response strobe, one cycle after the request |
| rsp_rdata | output | N_PORTS x DATA_W | Per-port read data |

## Verification
Two kinds of collision can land on one lock in a single cycle. Several acquires can race for the same free lock, and a release can meet an acquire. The bench provokes both on purpose: it points several ports at one lock in the same cycle. It also provokes them at random, by drawing every port's address from a pool of only four lock indices. For every port in every cycle, a bench model applies the releases first and then grants the acquires in port order. The 0 or 1 each port sees is compared with that model, and the checker also requires that no two ports are both given the same lock.

// File: rtl/lock_bank_pkg.sv
`timescale 1ns/1ps
package lock_bank_pkg;
   localparam int unsigned LOCK_REGION_BASE = 32'h800;
   localparam int unsigned STATUS_BYTE_ADDR = 32'h14;
   localparam int unsigned COUNT_FIELD_LSB  = 24;
   localparam int unsigned LOCKS_PER_UNIT   = 32;
   localparam int unsigned REGION_IDX_W     = 9;

   // One-hot count code placed in the status word
   function automatic logic [31:0] status_word(int unsigned n_locks);
      return 32'(n_locks / LOCKS_PER_UNIT) << COUNT_FIELD_LSB;
   endfunction
endpackage

// File: rtl/lock_bank_decode.sv
`timescale 1ns/1ps
module lock_bank_decode #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N_LOCKS = 32,
   parameter int unsigned IDX_W   = 5
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              acq,
   output logic              rel,
   output logic [IDX_W-1:0]  idx,
   output logic              hit_lock,
   output logic              hit_oor,
   output logic              hit_status
);
   import lock_bank_pkg::*;

   localparam int unsigned TOP_W = ADDR_W - 11;
   localparam logic [ADDR_W-3:0] STATUS_WORD_ADDR = (ADDR_W-2)'(STATUS_BYTE_ADDR >> 2);

   logic                    in_region;
   logic [REGION_IDX_W-1:0] word_idx;
   logic                    unused_lsbs;

   assign unused_lsbs = ^addr[1:0];
   assign in_region   = (addr[ADDR_W-1:11] == TOP_W'(1));
   assign word_idx    = addr[10:2];
   assign hit_lock    = in_region && (word_idx < REGION_IDX_W'(N_LOCKS));
   assign hit_oor     = in_region && !hit_lock;
   assign hit_status  = (addr[ADDR_W-1:2] == STATUS_WORD_ADDR);
   assign idx         = word_idx[IDX_W-1:0];
   assign acq         = valid && !write && hit_lock;
   assign rel         = valid && write && hit_lock && (wdata == '0);
endmodule

// File: rtl/lock_bank_resolve.sv
`timescale 1ns/1ps
module lock_bank_resolve #(
   parameter int unsigned N_PORTS = 2,
   parameter int unsigned N_LOCKS = 32,
   parameter int unsigned IDX_W   = 5
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [N_PORTS-1:0]             acq,
   input  logic [N_PORTS-1:0]             rel,
   input  logic [N_PORTS-1:0][IDX_W-1:0]  idx,
   output logic [N_PORTS-1:0]             won,
   output logic [N_LOCKS-1:0]             lock_state
);
   logic [N_LOCKS-1:0] state_q;
   logic [N_LOCKS-1:0] state_d;

   // Releases first, then acquires in ascending port order
   always_comb begin
      state_d = state_q;
      won     = '0;
      for (int p = 0; p < int'(N_PORTS); p++) begin
         if (rel[p]) state_d[idx[p]] = 1'b0;
      end
      for (int p = 0; p < int'(N_PORTS); p++) begin
         if (acq[p] && !state_d[idx[p]]) begin
            won[p]            = 1'b1;
            state_d[idx[p]]   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= '0;
      else     state_q <= state_d;
   end

   assign lock_state = state_q;
endmodule

// File: rtl/lock_bank_top.sv
`timescale 1ns/1ps
module lock_bank_top #(
   parameter int unsigned N_PORTS = 2,
   parameter int unsigned N_LOCKS = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [N_PORTS-1:0]               req_valid,
   input  logic [N_PORTS-1:0]               req_write,
   input  logic [N_PORTS-1:0][ADDR_W-1:0]   req_addr,
   input  logic [N_PORTS-1:0][DATA_W-1:0]   req_wdata,
   output logic [N_PORTS-1:0]               rsp_valid,
   output logic [N_PORTS-1:0][DATA_W-1:0]   rsp_rdata
);
   import lock_bank_pkg::*;

   localparam int unsigned IDX_W = $clog2(N_LOCKS);
   localparam logic [DATA_W-1:0] STATUS_VAL = DATA_W'(status_word(N_LOCKS));

   if (!(N_LOCKS == 32 || N_LOCKS == 64 || N_LOCKS == 128 || N_LOCKS == 256)) begin : g_bad_locks
      $error("lock_bank_top: N_LOCKS must be 32, 64, 128 or 256");
   end
   if (N_PORTS < 1) begin : g_bad_ports
      $error("lock_bank_top: N_PORTS must be at least 1");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("lock_bank_top: ADDR_W must be at least 12");
   end
   if (DATA_W < 28) begin : g_bad_data
      $error("lock_bank_top: DATA_W must hold the count field");
   end

   logic [N_PORTS-1:0]            acq;
   logic [N_PORTS-1:0]            rel;
   logic [N_PORTS-1:0][IDX_W-1:0] idx;
   logic [N_PORTS-1:0]            hit_lock;
   logic [N_PORTS-1:0]            hit_oor;
   logic [N_PORTS-1:0]            hit_status;
   logic [N_PORTS-1:0]            won;
   logic [N_LOCKS-1:0]            lock_state;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic [DATA_W-1:0] rdata_d;

      lock_bank_decode #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .N_LOCKS(N_LOCKS),
         .IDX_W  (IDX_W)
      ) u_dec (
         .valid     (req_valid[p]),
         .write     (req_write[p]),
         .addr      (req_addr[p]),
         .wdata     (req_wdata[p]),
         .acq       (acq[p]),
         .rel       (rel[p]),
         .idx       (idx[p]),
         .hit_lock  (hit_lock[p]),
         .hit_oor   (hit_oor[p]),
         .hit_status(hit_status[p])
      );

      always_comb begin
         rdata_d = '0;
         if (req_valid[p] && !req_write[p]) begin
            if (hit_status[p])    rdata_d = STATUS_VAL;
            else if (hit_lock[p]) rdata_d = DATA_W'(!won[p]);
            else if (hit_oor[p])  rdata_d = DATA_W'(1);
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            rsp_valid[p] <= 1'b0;
            rsp_rdata[p] <= '0;
         end else begin
            rsp_valid[p] <= req_valid[p];
            rsp_rdata[p] <= rdata_d;
         end
      end
   end

   lock_bank_resolve #(
      .N_PORTS(N_PORTS),
      .N_LOCKS(N_LOCKS),
      .IDX_W  (IDX_W)
   ) u_resolve (
      .clk       (clk),
      .rst       (rst),
      .acq       (acq),
      .rel       (rel),
      .idx       (idx),
      .won       (won),
      .lock_state(lock_state)
   );
endmodule

// File: rtl/lock_bank_sva.sv
`timescale 1ns/1ps
module lock_bank_sva #(
   parameter int unsigned N_PORTS = 2,
   parameter int unsigned N_LOCKS = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32
) (
   input logic                           clk,
   input logic                           rst,
   input logic [N_PORTS-1:0]             req_valid,
   input logic [N_PORTS-1:0]             req_write,
   input logic [N_PORTS-1:0][ADDR_W-1:0] req_addr,
   input logic [N_PORTS-1:0][DATA_W-1:0] rsp_rdata,
   input logic [N_PORTS-1:0]             rsp_valid,
   input logic [N_LOCKS-1:0]             lock_state
);
   import lock_bank_pkg::*;

   localparam int unsigned IDX_W = $clog2(N_LOCKS);
   localparam logic [DATA_W-1:0] STATUS_VAL = DATA_W'(status_word(N_LOCKS));

   logic [N_PORTS-1:0]            rd_lock;
   logic [N_PORTS-1:0]            rd_oor;
   logic [N_PORTS-1:0]            rd_stat;
   logic [N_PORTS-1:0][IDX_W-1:0] lidx;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
      logic region;
      assign region     = (req_addr[p][ADDR_W-1:11] == (ADDR_W-11)'(1));
      assign rd_lock[p] = req_valid[p] && !req_write[p] && region
                          && (req_addr[p][10:2] < 9'(N_LOCKS));
      assign rd_oor[p]  = req_valid[p] && !req_write[p] && region
                          && !(req_addr[p][10:2] < 9'(N_LOCKS));
      assign rd_stat[p] = req_valid[p] && !req_write[p]
                          && (req_addr[p] == ADDR_W'(STATUS_BYTE_ADDR));
      assign lidx[p]    = req_addr[p][IDX_W+1:2];

      p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (rst)
         req_valid[p] |=> rsp_valid[p]);
      p_no_rsp_idle_r11: assert property (@(posedge clk) disable iff (rst)
         !req_valid[p] |=> !rsp_valid[p]);
      p_status_word_r7: assert property (@(posedge clk) disable iff (rst)
         rd_stat[p] |=> (rsp_rdata[p] == STATUS_VAL));
      p_oor_read_one_r10: assert property (@(posedge clk) disable iff (rst)
         rd_oor[p] |=> (rsp_rdata[p] == DATA_W'(1)));
      p_grant_sets_lock_r2: assert property (@(posedge clk) disable iff (rst)
         rd_lock[p] |=> ((rsp_rdata[p] != '0) || lock_state[$past(lidx[p])]));
      p_lock_read_binary_r3: assert property (@(posedge clk) disable iff (rst)
         rd_lock[p] |=> (rsp_rdata[p][DATA_W-1:1] == '0));

      for (genvar q = p + 1; q < N_PORTS; q++) begin : g_pair
         p_single_winner_r8: assert property (@(posedge clk) disable iff (rst)
            (rd_lock[p] && rd_lock[q] && (lidx[p] == lidx[q]))
            |=> !((rsp_rdata[p] == '0) && (rsp_rdata[q] == '0)));
      end
   end

   p_reset_frees_r1: assert property (@(posedge clk)
      rst |=> (lock_state == '0));
endmodule

bind lock_bank_top lock_bank_sva #(
   .N_PORTS(N_PORTS),
   .N_LOCKS(N_LOCKS),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_sva (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .rsp_rdata (rsp_rdata),
   .rsp_valid (rsp_valid),
   .lock_state(lock_state)
);

// File: tb/lock_bank_top_tb_top.sv
`timescale 1ns/1ps
module lock_bank_top_tb_top;
   localparam int NP = 3;
   localparam int NL = 64;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam logic [31:0] STATUS_EXP = 32'h0200_0000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NP-1:0]         req_valid;
   logic [NP-1:0]         req_write;
   logic [NP-1:0][AW-1:0] req_addr;
   logic [NP-1:0][DW-1:0] req_wdata;
   logic [NP-1:0]         rsp_valid;
   logic [NP-1:0][DW-1:0] rsp_rdata;

   int checks   = 0;
   int failures = 0;
   logic [NL-1:0] m_state = '0;
   logic [NP-1:0][DW-1:0] exp_rd;
   logic [NP-1:0]         exp_v;
   string tag [NP];

   always #2.5 clk = ~clk;

   lock_bank_top #(.N_PORTS(NP), .N_LOCKS(NL), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

   function automatic logic [AW-1:0] lk(int i);
      return AW'(32'h800 + 4 * i);
   endfunction

   task automatic clear_reqs();
      req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
      for (int p = 0; p < NP; p++) tag[p] = "R11";
   endtask

   task automatic rd(int p, logic [AW-1:0] a, string t);
      req_valid[p] = 1'b1; req_write[p] = 1'b0; req_addr[p] = a; tag[p] = t;
   endtask

   task automatic wr(int p, logic [AW-1:0] a, logic [DW-1:0] d, string t);
      req_valid[p] = 1'b1; req_write[p] = 1'b1; req_addr[p] = a;
      req_wdata[p] = d; tag[p] = t;
   endtask

   // Reference: releases first, then reads in ascending port order
   task automatic predict();
      for (int p = 0; p < NP; p++) begin
         int wi = int'(req_addr[p][10:2]);
         if (req_valid[p] && req_write[p] && req_addr[p][11] && wi < NL
             && req_wdata[p] == '0)
            m_state[wi] = 1'b0;
      end
      for (int p = 0; p < NP; p++) begin
         int wi = int'(req_addr[p][10:2]);
         exp_v[p]  = req_valid[p];
         exp_rd[p] = '0;
         if (req_valid[p] && !req_write[p]) begin
            if (req_addr[p] == AW'(32'h14)) exp_rd[p] = STATUS_EXP;
            else if (req_addr[p][11]) begin
               if (wi < NL) begin
                  exp_rd[p] = DW'(m_state[wi]);
                  m_state[wi] = 1'b1;
               end else exp_rd[p] = 1;
            end
         end
      end
   endtask

   task automatic step();
      predict();
      @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         checks++;
         if (rsp_valid[p] !== exp_v[p]) begin
            failures++;
            $display("FAIL R11 port %0d rsp_valid=%b expected=%b", p, rsp_valid[p], exp_v[p]);
         end
         if (exp_v[p]) begin
            checks++;
            if (rsp_rdata[p] !== exp_rd[p]) begin
               failures++;
               $display("FAIL %s port %0d rdata=%h expected=%h", tag[p], p, rsp_rdata[p], exp_rd[p]);
            end
         end
      end
      clear_reqs();
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [AW-1:0] pool [4];
      void'($urandom(32'd4242));
      pool[0] = lk(0); pool[1] = lk(1); pool[2] = lk(62); pool[3] = lk(63);
      clear_reqs();
      repeat (3) @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         checks++;
         if (rsp_valid[p] !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset port %0d rsp_valid=%b expected=0", p, rsp_valid[p]);
         end
      end
      rst = 1'b0;

      rd(0, lk(0), "R1"); rd(1, lk(63), "R1"); step();
      rd(1, lk(0), "R3"); step();
      rd(2, lk(0), "R3"); step();
      wr(2, lk(0), 32'h5, "R5"); step();
      rd(1, lk(0), "R5"); step();
      wr(0, lk(0), 32'h0, "R4"); step();
      rd(2, lk(0), "R4"); step();
      rd(0, lk(5), "R8"); rd(1, lk(5), "R8"); rd(2, lk(5), "R8"); step();
      rd(1, lk(6), "R8"); rd(2, lk(6), "R8"); step();
      wr(2, lk(5), 32'h0, "R9"); rd(1, lk(5), "R9"); step();
      rd(0, lk(5), "R9"); step();
      rd(0, AW'(32'h14), "R7"); wr(1, AW'(32'h14), 32'hFFFF_FFFF, "R7"); step();
      rd(2, AW'(32'h14), "R7"); step();
      rd(0, lk(64), "R10"); wr(1, lk(64), 32'h0, "R10"); step();
      rd(0, lk(0), "R10"); rd(1, lk(100), "R10"); step();
      wr(0, AW'(32'h100), 32'h0, "R12"); rd(1, AW'(32'h100), "R12"); step();
      rd(2, lk(0), "R12"); step();
      rd(0, lk(7) | AW'(2), "R6"); rd(1, lk(8) | AW'(3), "R6"); step();
      rd(2, lk(7), "R6"); rd(0, lk(9), "R6"); step();

      for (int it = 0; it < 400; it++) begin
         for (int p = 0; p < NP; p++) begin
            if ($urandom % 4 != 0) begin
               int k = int'($urandom % 10);
               if (k == 0) rd(p, AW'(32'h14), "R7");
               else if (k == 1) begin
                  if ($urandom % 2 == 0) rd(p, lk(64 + int'($urandom % 8)), "R10");
                  else wr(p, lk(64 + int'($urandom % 8)), 32'h0, "R10");
               end else if (k == 2) rd(p, AW'(32'h100), "R12");
               else if (k < 6)
                  wr(p, pool[$urandom % 4], ($urandom % 4 == 0) ? DW'($urandom | 1) : '0, "R4");
               else rd(p, pool[$urandom % 4], "R2");
            end
         end
         step();
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule